// File: doc/BRIEF.md
# Serial Byte Transmitter with Fractional Stop and Line Break

This block turns bytes offered on a valid/ready input into an asynchronous serial stream. Each frame is a low start bit, eight data bits with the least significant first, and a high stop interval. The stop interval can be half a bit, one bit, one and a half bits or two bits long. All timing comes from a single-cycle baud tick that the surrounding logic pulses sixteen times per bit period. When the line is idle it is held high.

On request the block drives a long low level on the line instead of a frame. This break lasts thirteen bit times when the long-break option is set and ten bit times when it is not. One bit time of high level always follows a break.

A companion clock pin can be enabled for synchronous receivers. This pin makes one full period inside each data bit and stays quiet during the start and stop bits. Its resting level and which of its edges marks the capture point are both configurable. The configuration inputs are captured when a frame or break starts, so changing them during a frame has no effect on that frame.

Top module: `sertx_core`

## Requirements
- R1: After reset, with all configuration inputs at zero, `txd` is 1, `in_ready` is 1 and `sclk` is 0.
- R2: After a byte is accepted, `txd` is 0 for 16 baud ticks (start bit). It then carries data bits 0 through 7 in that order, each for 16 ticks.
- R3: The stop interval is high on `txd`. Its length is set by `cfg_stop` as follows: 2'b00 gives 16 ticks, 2'b01 gives 8 ticks, 2'b10 gives 32 ticks and 2'b11 gives 24 ticks. `in_ready` returns to 1 exactly when the last stop tick has been consumed.
- R4: A byte is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` stays 0 from that edge until the frame, or a break, has finished.
- R5: When `cfg_lin` is 1 and a break is accepted, `txd` is low for 208 ticks (13 bit times). It is then high for 16 ticks, after which `in_ready` returns to 1.
- R6: When `cfg_lin` is 0 and a break is accepted, `txd` is low for 160 ticks (10 bit times). It is then high for 16 ticks before the block is ready again.
- R7: `brk_req` is acted on only while the block is idle. In that state it takes priority over a byte: `in_ready` is 0 while `brk_req` is 1. A `brk_req` pulse during a frame leaves the frame and the ready timing unchanged, and no break follows.
- R8: With `cfg_clken` at 0, `sclk` stays at the `cfg_cpol` level throughout the frame.
- R9: With `cfg_clken` at 1, `sclk` makes one full period during each data bit. Ticks 0 to 7 of the bit are at rest and ticks 8 to 15 are at the opposite level when `cfg_cpha` is 0. With `cfg_cpha` at 1 the two halves are swapped. There are no pulses during the start and stop bits.
- R10: Outside the data bits, `sclk` rests at 0 when `cfg_cpol` is 0 and at 1 when it is 1.
- R11: The configuration inputs are captured when a frame starts. Changing them during a frame alters neither its stop length nor its clock level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit period |
| cfg_stop | input | 2 | Stop interval code |
| cfg_lin | input | 1 | Selects a 13-bit break instead of a 10-bit break |
| cfg_clken | input | 1 | Enables pulses on the clock pin |
| cfg_cpol | input | 1 | Resting level of the clock pin |
| cfg_cpha | input | 1 | Clock phase: 1 makes the second edge of each bit the capture edge |
| brk_req | input | 1 | Request to send a break |
| in_valid | input | 1 | Byte on `in_data` is offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Block can accept a byte |
| txd | output | 1 | Serial data line |
| sclk | output | 1 | Synchronous clock pin |

## Verification
Some properties are checked on every cycle. The total tick count of each frame or break is checked against the captured stop code and break option. The captured configuration must not change while the block is busy. A break must be followed by a high stop interval. A start bit must follow every handshake. No break may begin in the middle of a frame, and the clock pin must stay quiet outside the data bits. The bench scenarios cover what the cycle checks cannot see: data bit order, the exact clock-pin waveform for each polarity and phase, the idle levels after reset, the priority of a break over a byte that arrives at the same time, and the fact that configuration changes made during a frame have no effect.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_DATA  = 3'd2,
      ST_STOP  = 3'd3,
      ST_BRK   = 3'd4
   } tx_state_e;

   typedef struct packed {
      logic [1:0] stop;
      logic       lin;
      logic       clken;
      logic       cpol;
      logic       cpha;
   } tx_cfg_t;

   // stop interval length in baud ticks for a given code
   function automatic int unsigned stop_len(input logic [1:0] code, input int unsigned osr);
      case (code)
         2'b00:   return osr;
         2'b01:   return osr / 2;
         2'b10:   return 2 * osr;
         default: return osr + osr / 2;
      endcase
   endfunction

endpackage

// File: rtl/sertx_tickcnt.sv
module sertx_tickcnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         clr,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/sertx_clkgen.sv
module sertx_clkgen #(
   parameter bit HAS_SCLK = 1'b1
) (
   input  logic busy,
   input  logic in_data,
   input  logic first_half,
   input  logic clken,
   input  logic cpol_q,
   input  logic cpha_q,
   input  logic cpol_live,
   output logic sclk
);
   generate
      if (HAS_SCLK) begin : g_pin
         logic rest;
         logic active;
         always_comb begin
            rest   = busy ? cpol_q : cpol_live;
            active = in_data & clken & (first_half == cpha_q);
            sclk   = rest ^ active;
         end
      end else begin : g_none
         always_comb sclk = cpol_live;
      end
   endgenerate
endmodule

// File: rtl/sertx_core.sv
module sertx_core
   import sertx_pkg::*;
#(
   parameter int OSR          = 16,
   parameter int DW           = 8,
   parameter int LIN_BRK_BITS = 13,
   parameter int STD_BRK_BITS = 10,
   parameter bit HAS_SCLK     = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          baud_tick,
   input  logic [1:0]    cfg_stop,
   input  logic          cfg_lin,
   input  logic          cfg_clken,
   input  logic          cfg_cpol,
   input  logic          cfg_cpha,
   input  logic          brk_req,
   input  logic          in_valid,
   input  logic [DW-1:0] in_data,
   output logic          in_ready,
   output logic          txd,
   output logic          sclk
);
   localparam int MAXB = (LIN_BRK_BITS > STD_BRK_BITS) ? LIN_BRK_BITS : STD_BRK_BITS;
   localparam int CW   = $clog2(OSR * MAXB + 1);
   localparam int HALF = OSR / 2;
   localparam int BIW  = (DW > 1) ? $clog2(DW) : 1;
   localparam int FW   = $clog2(OSR * (MAXB + DW + 3) + 1);

   generate
      if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
         $error("OSR must be even and at least 4");
      end
      if (DW < 2) begin : g_bad_dw
         $error("DW must be at least 2");
      end
      if (LIN_BRK_BITS < 1 || STD_BRK_BITS < 1) begin : g_bad_brk
         $error("break lengths must be positive");
      end
   endgenerate

   tx_state_e       state;
   tx_cfg_t         cfg_q;
   tx_cfg_t         cfg_in;
   logic [DW-1:0]   shreg;
   logic [BIW-1:0]  bidx;
   logic            after_brk;
   logic [CW-1:0]   tcnt;
   logic [CW-1:0]   lim;
   logic            per_end;
   logic            idle;

   assign cfg_in = '{stop: cfg_stop, lin: cfg_lin, clken: cfg_clken, cpol: cfg_cpol, cpha: cfg_cpha};
   assign idle   = (state == ST_IDLE);

   always_comb begin
      case (state)
         ST_STOP: lim = after_brk ? CW'(OSR) : CW'(stop_len(cfg_q.stop, OSR));
         ST_BRK:  lim = cfg_q.lin ? CW'(OSR * LIN_BRK_BITS) : CW'(OSR * STD_BRK_BITS);
         default: lim = CW'(OSR);
      endcase
   end

   assign per_end = baud_tick && !idle && (tcnt == lim - CW'(1));

   sertx_tickcnt #(.W(CW)) u_tcnt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (baud_tick),
      .clr   (idle || per_end),
      .cnt   (tcnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cfg_q     <= '0;
         shreg     <= '0;
         bidx      <= '0;
         after_brk <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (brk_req) begin
                  cfg_q     <= cfg_in;
                  after_brk <= 1'b1;
                  state     <= ST_BRK;
               end else if (in_valid) begin
                  cfg_q     <= cfg_in;
                  shreg     <= in_data;
                  after_brk <= 1'b0;
                  state     <= ST_START;
               end
            end
            ST_START: if (per_end) begin
               bidx  <= '0;
               state <= ST_DATA;
            end
            ST_DATA: if (per_end) begin
               shreg <= shreg >> 1;
               bidx  <= bidx + 1'b1;
               if (bidx == BIW'(DW - 1)) state <= ST_STOP;
            end
            ST_STOP: if (per_end) state <= ST_IDLE;
            ST_BRK:  if (per_end) state <= ST_STOP;
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      case (state)
         ST_START, ST_BRK: txd = 1'b0;
         ST_DATA:          txd = shreg[0];
         default:          txd = 1'b1;
      endcase
   end

   assign in_ready = idle && !brk_req;

   sertx_clkgen #(.HAS_SCLK(HAS_SCLK)) u_clkgen (
      .busy       (!idle),
      .in_data    (state == ST_DATA),
      .first_half (tcnt < CW'(HALF)),
      .clken      (cfg_q.clken),
      .cpol_q     (cfg_q.cpol),
      .cpha_q     (cfg_q.cpha),
      .cpol_live  (cfg_cpol),
      .sclk       (sclk)
   );

   // ---------------- checks ----------------
   logic [FW-1:0] frm_ticks;
   logic [FW-1:0] exp_total;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          frm_ticks <= '0;
      else if (idle)       frm_ticks <= '0;
      else if (baud_tick)  frm_ticks <= frm_ticks + 1'b1;
   end

   always_comb begin
      if (after_brk)
         exp_total = cfg_q.lin ? FW'(OSR * (LIN_BRK_BITS + 1)) : FW'(OSR * (STD_BRK_BITS + 1));
      else
         exp_total = FW'(OSR * (DW + 1)) + FW'(stop_len(cfg_q.stop, OSR));
   end

   // R3 R5 R6
   frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && $past(state) == ST_STOP) |-> (frm_ticks == exp_total));

   // R4
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (state == ST_START && !txd && !in_ready));

   // R5
   brk_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_BRK && state != ST_BRK) |-> (state == ST_STOP && txd));

   // R7
   no_mid_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && state != ST_BRK) |=> (state != ST_BRK));

   // R11
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && $past(state) != ST_IDLE) |-> $stable(cfg_q));

   // R9
   sclk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && $past(state) != ST_IDLE && state != ST_DATA && $past(state) != ST_DATA)
      |-> $stable(sclk));

endmodule

// File: tb/sertx_core_test.sv
`timescale 1ns/1ps
module sertx_core_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic [1:0] cfg_stop = 2'b00;
   logic       cfg_lin = 1'b0;
   logic       cfg_clken = 1'b0;
   logic       cfg_cpol = 1'b0;
   logic       cfg_cpha = 1'b0;
   logic       brk_req = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_ready;
   logic       txd;
   logic       sclk;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;
   always @(posedge clk) baud_tick <= rst_n ? ~baud_tick : 1'b0;

   sertx_core uut (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
      .cfg_stop(cfg_stop), .cfg_lin(cfg_lin), .cfg_clken(cfg_clken),
      .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .brk_req(brk_req),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .txd(txd), .sclk(sclk)
   );

   // {data[7:0], stop[1:0], clken, cpol, cpha}
   localparam logic [12:0] VEC [7] = '{
      {8'hA5, 2'b00, 1'b0, 1'b0, 1'b0},
      {8'h3C, 2'b01, 1'b1, 1'b0, 1'b0},
      {8'h81, 2'b10, 1'b1, 1'b0, 1'b1},
      {8'hF0, 2'b11, 1'b1, 1'b1, 1'b0},
      {8'h5A, 2'b00, 1'b1, 1'b1, 1'b1},
      {8'h00, 2'b01, 1'b0, 1'b1, 1'b0},
      {8'hFF, 2'b10, 1'b1, 1'b0, 1'b0}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int stop_ticks(input logic [1:0] c);
      case (c)
         2'b00: return 16;
         2'b01: return 8;
         2'b10: return 32;
         default: return 24;
      endcase
   endfunction

   task automatic to_tick();
      while (!baud_tick) begin
         @(negedge clk);
         brk_req = 1'b0;
      end
   endtask

   task automatic run_frame(input logic [7:0] d, input logic [1:0] st, input bit ce,
                            input bit cp, input bit ch, input bit disturb);
      int t;
      cfg_stop = st; cfg_clken = ce; cfg_cpol = cp; cfg_cpha = ch;
      t = 144 + stop_ticks(st);
      @(negedge clk);
      chk(in_ready == 1'b1, "R4 ready before frame", in_ready, 1);
      in_valid = 1'b1; in_data = d;
      @(negedge clk);
      in_valid = 1'b0;
      for (int k = 0; k <= t; k++) begin
         int e_txd;
         int e_sclk;
         to_tick();
         if (k < 16) e_txd = 0;
         else if (k < 144) e_txd = d[(k - 16) / 16];
         else e_txd = 1;
         e_sclk = cp;
         if (k >= 16 && k < 144 && ce && ((((k - 16) % 16) < 8) == ch)) e_sclk = !cp;
         if (k < t) begin
            chk(txd == e_txd[0], (k < 144) ? "R2 frame bit" : "R3 stop level", txd, e_txd);
            chk(sclk == e_sclk[0], ce ? "R9 clock pin waveform" : "R8 clock pin held", sclk, e_sclk);
            chk(in_ready == 1'b0, "R4 busy not ready", in_ready, 0);
         end else begin
            chk(in_ready == 1'b1, "R3 ready after stop length", in_ready, 1);
            chk(txd == 1'b1, "R3 idle high after stop", txd, 1);
         end
         if (disturb && k == 5) begin
            // R11: changes during the frame must not matter
            cfg_stop = st + 2'd1;
            cfg_cpol = !cp;
            cfg_clken = !ce;
         end
         if (disturb && k == 40) brk_req = 1'b1;   // R7: ignored while busy
         @(negedge clk);
         brk_req = 1'b0;
      end
      cfg_stop = st; cfg_clken = ce; cfg_cpol = cp; cfg_cpha = ch;
   endtask

   task automatic run_break(input bit lin, input bit with_byte);
      int lo;
      lo = lin ? 208 : 160;
      cfg_lin = lin;
      @(negedge clk);
      brk_req = 1'b1;
      in_valid = with_byte;
      in_data = 8'h55;
      #0.5;
      chk(in_ready == 1'b0, "R7 break blocks byte", in_ready, 0);
      @(negedge clk);
      brk_req = 1'b0;
      in_valid = 1'b0;
      for (int k = 0; k <= lo + 16; k++) begin
         to_tick();
         if (k < lo + 16) begin
            chk(txd == (k >= lo), lin ? "R5 long break level" : "R6 short break level", txd, (k >= lo));
            chk(in_ready == 1'b0, "R4 busy during break", in_ready, 0);
         end else begin
            chk(in_ready == 1'b1, lin ? "R5 ready after break" : "R6 ready after break", in_ready, 1);
         end
         @(negedge clk);
      end
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         chk(txd == 1'b1 && in_ready == 1'b1, "R7 no frame after break", txd, 1);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(txd == 1'b1, "R1 reset txd", txd, 1);
      chk(in_ready == 1'b1, "R1 reset ready", in_ready, 1);
      chk(sclk == 1'b0, "R1 reset sclk", sclk, 0);

      for (int i = 0; i < 7; i++)
         run_frame(VEC[i][12:5], VEC[i][4:3], VEC[i][2], VEC[i][1], VEC[i][0], 1'b0);

      // R10: idle level follows polarity
      cfg_cpol = 1'b1;
      @(negedge clk);
      chk(sclk == 1'b1, "R10 idle high", sclk, 1);
      cfg_cpol = 1'b0;
      @(negedge clk);
      chk(sclk == 1'b0, "R10 idle low", sclk, 0);

      run_frame(8'hC3, 2'b01, 1'b1, 1'b0, 1'b1, 1'b1);   // R11 and R7 disturbances
      run_break(1'b1, 1'b0);                              // R5
      run_break(1'b0, 1'b1);                              // R6, R7 priority
      run_frame(8'h96, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0);   // frame after break

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog act=0 exp=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule